// File: doc/BRIEF.md
# Implicit-Operand 16-bit ALU

This block is the arithmetic and logic engine of a small 16-bit processor whose ALU instructions name no registers. Both operands always come from two fixed source registers and the answer always lands in one fixed result register, so the instruction spends its whole 12-bit payload on an operation code. Thirteen codes are defined today: add, subtract and their carry-chained forms, increment, decrement, two's complement, invert, AND, OR, pass-through, byte concatenation and an 8x8 unsigned multiply. The wide code space leaves room for many more.

The surrounding control unit pulses `start` for one cycle with the code and both operands valid. One clock later the result register and the zero and carry flags hold the new values, and `done` pulses. The zero flag feeds the processor's conditional moves. The carry flag is both an output and the carry input of the two chained operations. The input side has no back-pressure. A `start` is accepted in every cycle, including back-to-back cycles, and each one gives exactly one `done` a cycle later. The result and the flags hold their values until a later accepted operation changes them.

Top module: `implicit_alu`

## Requirements
- R1: While reset is asserted, and after it is released, `result` is 0x0000, `zero_flag` is 1, `carry_flag` is 0 and `done` is 0.
- R2: `done` is high in exactly the cycle after each cycle in which `start` is high, and `result` and the flags take their new values in that same cycle. Back-to-back starts are all accepted.
- R3: Code 0x100 gives src1+src2 and code 0x300 gives src1+src2+carry_flag. For both, `carry_flag` becomes the carry out of bit 15.
- R4: Code 0x200 gives src1-src2 and code 0x000 gives src1-src2-carry_flag. For both, `carry_flag` becomes 1 when a borrow occurs and 0 when it does not.
- R5: Code 0x700 gives src1+1 and code 0xB00 gives src1-1, and src2 is ignored. `carry_flag` becomes 1 on a wrap from 0xFFFF to 0x0000 for increment, or from 0x0000 to 0xFFFF for decrement, and 0 otherwise.
- R6: Code 0x400 gives ~src1, 0x500 gives src1&src2, 0x600 gives src1|src2 and 0xA00 gives src1. These operations leave `carry_flag` unchanged.
- R7: Code 0x800 gives the two's complement of src1 (0-src1) and leaves `carry_flag` unchanged.
- R8: Code 0x900 gives {src1[7:0], src2[7:0]}, with the src1 byte in the high half. It leaves `carry_flag` unchanged.
- R9: Code 0xC00 gives the 16-bit unsigned product src1[7:0]*src2[7:0] and leaves `carry_flag` unchanged.
- R10: After every defined operation, `zero_flag` is 1 exactly when the new `result` is 0x0000. `zero_flag` always equals (`result` == 0).
- R11: A code is defined only when bits [7:0] are zero and bits [11:8] are 0x0 to 0xC. Any other code still raises `done`, but it leaves `result`, `zero_flag` and `carry_flag` unchanged.
- R12: In a cycle after one without `start`, `done` is 0 and `result` and both flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; code and operands sampled with it |
| op_code | input | 12 | Operation select |
| src1 | input | 16 | First implicit operand |
| src2 | input | 16 | Second implicit operand |
| result | output | 16 | Result register |
| done | output | 1 | Pulses one cycle after start |
| zero_flag | output | 1 | Result-is-zero status |
| carry_flag | output | 1 | Carry/borrow status, also chained carry input |

## Verification
A wrong stored carry stays hidden until a later chained add or subtract reads it, so the vector walk sets the carry on purpose, runs non-carry operations over it, and then consumes it. A wrong update mask, where a logic, multiply or concatenate operation disturbs the carry, shows up at the carry pin in the cycle of `done` for that operation. A decode error that treats an undefined code as defined changes `result` at that same `done`, so the bench places undefined codes right after a known non-zero result.

// File: rtl/implicit_alu_pkg.sv
package implicit_alu_pkg;
  // Operation selector, numbered to match the upper nibble of the code.
  typedef enum logic [3:0] {
    OP_SUBC = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_ADDC = 4'h3,
    OP_INV  = 4'h4,
    OP_AND  = 4'h5,
    OP_OR   = 4'h6,
    OP_INC  = 4'h7,
    OP_CPL2 = 4'h8,
    OP_CAT  = 4'h9,
    OP_PASS = 4'hA,
    OP_DEC  = 4'hB,
    OP_MUL8 = 4'hC
  } alu_op_e;

  localparam int unsigned SEL_W   = 4;
  localparam int unsigned NUM_OPS = 13;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import implicit_alu_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic [CODE_W-1:0] code,
  output alu_op_e           op,
  output logic              known
);
  localparam int unsigned LOW_W = CODE_W - SEL_W;

  logic [SEL_W-1:0] sel;

  assign sel   = code[CODE_W-1 -: SEL_W];
  assign op    = alu_op_e'(sel);
  assign known = (code[LOW_W-1:0] == '0) && (32'(sel) < NUM_OPS);
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import implicit_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         is_arith
);
  localparam int unsigned EW = W + 1;

  logic [EW-1:0] ea, eb, ec, one, ext;

  assign ea  = {1'b0, a};
  assign eb  = {1'b0, b};
  assign ec  = {{W{1'b0}}, cin};
  assign one = {{W{1'b0}}, 1'b1};

  always_comb begin
    ext      = '0;
    is_arith = 1'b1;
    unique case (op)
      OP_ADD:  ext = ea + eb;
      OP_ADDC: ext = ea + eb + ec;
      OP_SUB:  ext = ea - eb;        // top bit is the borrow
      OP_SUBC: ext = ea - eb - ec;
      OP_INC:  ext = ea + one;
      OP_DEC:  ext = ea - one;
      default: is_arith = 1'b0;
    endcase
  end

  assign res  = ext[W-1:0];
  assign cout = ext[W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import implicit_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] prod;

  assign prod = W'(a[HALF-1:0]) * W'(b[HALF-1:0]);

  always_comb begin
    unique case (op)
      OP_INV:  res = ~a;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_CPL2: res = (~a) + W'(1);
      OP_CAT:  res = {a[HALF-1:0], b[HALF-1:0]};
      OP_PASS: res = a;
      OP_MUL8: res = prod;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/implicit_alu.sv
module implicit_alu
  import implicit_alu_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] op_code,
  input  logic [W-1:0]      src1,
  input  logic [W-1:0]      src2,
  output logic [W-1:0]      result,
  output logic              done,
  output logic              zero_flag,
  output logic              carry_flag
);
  alu_op_e      op;
  logic         known;
  logic [W-1:0] arith_res, bit_res, nxt;
  logic         arith_cout, is_arith;

  alu_op_decode #(.CODE_W(CODE_W)) dec_i (
    .code (op_code),
    .op   (op),
    .known(known)
  );

  alu_arith #(.W(W)) arith_i (
    .op      (op),
    .a       (src1),
    .b       (src2),
    .cin     (carry_flag),
    .res     (arith_res),
    .cout    (arith_cout),
    .is_arith(is_arith)
  );

  alu_bitwise #(.W(W)) bitw_i (
    .op (op),
    .a  (src1),
    .b  (src2),
    .res(bit_res)
  );

  assign nxt = is_arith ? arith_res : bit_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      done       <= 1'b0;
      zero_flag  <= 1'b1;
      carry_flag <= 1'b0;
    end else begin
      done <= start;
      if (start && known) begin
        result    <= nxt;
        zero_flag <= (nxt == '0);
        if (is_arith) carry_flag <= arith_cout;
      end
    end
  end
endmodule

// File: rtl/implicit_alu_chk.sv
module implicit_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [11:0] op_code,
  input logic [15:0] src1,
  input logic [15:0] src2,
  input logic [15:0] result,
  input logic        done,
  input logic        zero_flag,
  input logic        carry_flag
);
  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(result) && $stable(zero_flag) && $stable(carry_flag)));

  // R11
  unknown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_code[7:0] != 8'h00 || op_code[11:8] > 4'hC))
      |=> ($stable(result) && $stable(zero_flag) && $stable(carry_flag)));

  // R10
  zero_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag == (result == 16'h0000));

  // R6
  and_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_code == 12'h500) |=> $stable(carry_flag));

  // R8
  concat_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_code == 12'h900) |=> (result == {$past(src1[7:0]), $past(src2[7:0])}));
endmodule

bind implicit_alu implicit_alu_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .op_code   (op_code),
  .src1      (src1),
  .src2      (src2),
  .result    (result),
  .done      (done),
  .zero_flag (zero_flag),
  .carry_flag(carry_flag)
);

// File: tb/implicit_alu_tb_top.sv
module implicit_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] op_code = '0;
  logic [15:0] src1 = '0, src2 = '0;
  logic [15:0] result;
  logic        done, zero_flag, carry_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  implicit_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .src1(src1), .src2(src2), .result(result), .done(done),
    .zero_flag(zero_flag), .carry_flag(carry_flag)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] code;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic        z;
    logic        c;
  } vec_t;

  localparam int NV = 21;
  // Walked in order: the carry flag chains from one entry to the next.
  localparam vec_t VECS [NV] = '{
    '{4'd3,  12'h100, 16'h1234, 16'h4321, 16'h5555, 1'b0, 1'b0}, // R3 add
    '{4'd3,  12'h100, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1}, // R3 carry out
    '{4'd3,  12'h300, 16'h0001, 16'h0001, 16'h0003, 1'b0, 1'b0}, // R3 add with carry 1
    '{4'd4,  12'h200, 16'h0005, 16'h0007, 16'hFFFE, 1'b0, 1'b1}, // R4 borrow
    '{4'd4,  12'h000, 16'h0010, 16'h0001, 16'h000E, 1'b0, 1'b0}, // R4 sub with borrow in
    '{4'd4,  12'h000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R4 zero
    '{4'd5,  12'h700, 16'hFFFF, 16'h1234, 16'h0000, 1'b1, 1'b1}, // R5 inc wrap
    '{4'd6,  12'h500, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0, 1'b1}, // R6 and, carry held
    '{4'd5,  12'hB00, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1}, // R5 dec wrap
    '{4'd6,  12'h400, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1}, // R6 invert
    '{4'd6,  12'h600, 16'h1200, 16'h0034, 16'h1234, 1'b0, 1'b1}, // R6 or
    '{4'd7,  12'h800, 16'h0001, 16'h5555, 16'hFFFF, 1'b0, 1'b1}, // R7 negate, carry held
    '{4'd5,  12'hB00, 16'h0005, 16'h0000, 16'h0004, 1'b0, 1'b0}, // R5 dec no wrap
    '{4'd7,  12'h800, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R7 negate zero
    '{4'd8,  12'h900, 16'hAB12, 16'hCD34, 16'h1234, 1'b0, 1'b0}, // R8 concat
    '{4'd9,  12'hC00, 16'h12FF, 16'h34FF, 16'hFE01, 1'b0, 1'b0}, // R9 mul8 max
    '{4'd6,  12'hA00, 16'hBEEF, 16'h0000, 16'hBEEF, 1'b0, 1'b0}, // R6 pass
    '{4'd11, 12'hD00, 16'h0000, 16'h0000, 16'hBEEF, 1'b0, 1'b0}, // R11 high nibble out of range
    '{4'd11, 12'h101, 16'h0000, 16'h0000, 16'hBEEF, 1'b0, 1'b0}, // R11 low bits set
    '{4'd9,  12'hC00, 16'h0010, 16'hFF00, 16'h0000, 1'b1, 1'b0}, // R9/R10 product zero
    '{4'd3,  12'h300, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b0}  // R3 add with carry 0
  };

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {done,z,c,result} actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one start at a falling edge; return at the next falling edge,
  // after the capturing rising edge.
  task automatic issue(input logic [11:0] c, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    start = 1'b1; op_code = c; src1 = a; src2 = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    check("R1 in reset", {done, zero_flag, carry_flag, result}, {1'b0, 1'b1, 1'b0, 16'h0000});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {done, zero_flag, carry_flag, result}, {1'b0, 1'b1, 1'b0, 16'h0000});

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].code, VECS[i].a, VECS[i].b);
      check($sformatf("R%0d vec %0d", VECS[i].req, i),
            {done, zero_flag, carry_flag, result},
            {1'b1, VECS[i].z, VECS[i].c, VECS[i].res});
    end

    // R12: idle cycle with changing inputs, nothing moves (result 8000, z0, c0)
    op_code = 12'h100; src1 = 16'h1111; src2 = 16'h2222;
    @(negedge clk);
    check("R12 idle hold", {done, zero_flag, carry_flag, result}, {1'b0, 1'b0, 1'b0, 16'h8000});

    // R2: back-to-back starts, each answered in the next cycle
    @(negedge clk);
    start = 1'b1; op_code = 12'h100; src1 = 16'h0002; src2 = 16'h0003;
    @(negedge clk);
    check("R2 first of pair", {done, zero_flag, carry_flag, result}, {1'b1, 1'b0, 1'b0, 16'h0005});
    op_code = 12'h700; src1 = 16'h0009;
    @(negedge clk);
    start = 1'b0;
    check("R2 second of pair", {done, zero_flag, carry_flag, result}, {1'b1, 1'b0, 1'b0, 16'h000A});
    @(negedge clk);
    check("R2 single pulse", {done, zero_flag, carry_flag, result}, {1'b0, 1'b0, 1'b0, 16'h000A});

    // R11 then R3: undefined code must not touch a set carry
    issue(12'h100, 16'h8000, 16'h8000);
    check("R3 carry set", {done, zero_flag, carry_flag, result}, {1'b1, 1'b1, 1'b1, 16'h0000});
    issue(12'hF00, 16'h1234, 16'h1234);
    check("R11 carry kept", {done, zero_flag, carry_flag, result}, {1'b1, 1'b1, 1'b1, 16'h0000});
    issue(12'h300, 16'h0000, 16'h0000);
    check("R3 chained carry", {done, zero_flag, carry_flag, result}, {1'b1, 1'b0, 1'b0, 16'h0001});

    // R1: reset in mid-run restores the reset state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", {done, zero_flag, carry_flag, result}, {1'b0, 1'b1, 1'b0, 16'h0000});
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule